// File: doc/BRIEF.md
# Decode-Stage Branch Target Checker

This block sits at the exit of an instruction decode stage and looks at a bundle of up to `W` instructions per cycle, slot 0 being the oldest. Two kinds of early fault are caught. The first is a direct unconditional control instruction whose target, computed from its own encoding, does not match the target the front end predicted. The second is an instruction that the predictor marked taken although it is not a control instruction. The branch predictor and the target adder sit outside the block. Their results arrive on the slot inputs.

Only the oldest faulting slot in a bundle acts. It produces a one-cycle redirect record for fetch. The record carries the thread, a sequence-number bound equal to the faulting instruction's own number, the corrected next PC and a taken bit. The faulting instruction still goes downstream, with its predicted target overwritten by the correct one. Later slots in the bundle are not passed on. Those of the same thread with a larger sequence number are flagged as killed, and the rest are flagged as held for a later cycle. Passed instructions with no source operands are tagged ready to issue. Two running counters record how many target checks were made and how many of them failed.

All outputs are registered, so they appear one clock after the bundle is presented.

Top module: `dtb_checker`

## Requirements
- R1: While `rst` is high at a clock edge, and on the first sample after that edge, every output is zero, both counters included.
- R2: A valid slot with `in_ctrl`, `in_direct` and `in_uncond` all set, whose `in_calc_tgt` differs from `in_pred_tgt`, raises `rd_valid` one cycle later. In that same cycle `rd_next_pc` equals `in_calc_tgt`, `rd_seq` and `rd_tid` equal that slot's values, and `rd_nonctrl` is 0.
- R3: `rd_taken` is 1 exactly when `rd_next_pc` differs from the faulting slot's PC plus 4, where 4 is the instruction size in bytes.
- R4: Any valid slot after the faulting one with the same thread id and a sequence number larger than the faulting one's, compared as unsigned 16-bit values, has `out_kill` set and `out_valid` clear.
- R5: Valid slots up to and including the faulting slot have `out_valid` set. Valid slots after it that are not killed have `out_hold` set. With no fault in the bundle, every valid slot has `out_valid` set. At most one of `out_valid`, `out_kill` and `out_hold` is set per slot.
- R6: For the faulting slot, the corresponding field of `out_pred_tgt` carries the corrected target, which is `rd_next_pc`. Every other passed slot carries its own `in_pred_tgt` unchanged.
- R7: A valid slot with `in_pred_taken` set and `in_ctrl` clear is a fault. It gives `rd_nonctrl`=1, `rd_next_pc` equal to its PC plus 4, and `rd_taken`=0.
- R8: When several slots fault, only the lowest-index one defines the redirect record.
- R9: A control instruction that is conditional or indirect never raises a redirect, whatever its targets are.
- R10: `out_ready[i]` is 1 exactly when slot i is passed and `in_no_src[i]` is 1.
- R11: `cnt_checked` grows by the number of valid direct unconditional control slots up to and including the faulting slot, or by the number in the whole bundle when no slot faults. `cnt_mispred` grows by 1 for each target-mismatch redirect and not for a non-control redirect. Both counters wrap modulo 2^16.
- R12: Slots with `in_valid` clear produce no output flags, a zero target field, and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | W | Slot holds an instruction |
| in_tid | input | W*TW | Thread id per slot |
| in_seq | input | W*SW | Sequence number per slot |
| in_pc | input | W*AW | Instruction address per slot |
| in_pred_taken | input | W | Predictor said taken |
| in_pred_tgt | input | W*AW | Predicted target per slot |
| in_ctrl | input | W | Instruction is a control transfer |
| in_direct | input | W | Target is encoded in the instruction |
| in_uncond | input | W | Control transfer is unconditional |
| in_calc_tgt | input | W*AW | Target computed by the decode adder |
| in_no_src | input | W | Instruction reads no source register |
| out_valid | output | W | Slot passed downstream |
| out_kill | output | W | Slot squashed as younger than the fault |
| out_hold | output | W | Slot not processed this cycle |
| out_ready | output | W | Passed slot may issue at once |
| out_pred_tgt | output | W*AW | Target passed downstream, corrected for the faulting slot |
| rd_valid | output | 1 | Redirect record valid |
| rd_tid | output | TW | Thread of the redirect |
| rd_seq | output | SW | Sequence bound: the faulting instruction's own number |
| rd_next_pc | output | AW | Address fetch must restart from |
| rd_taken | output | 1 | Next PC is not the fall-through address |
| rd_nonctrl | output | 1 | Fault was a taken prediction on a non-control instruction |
| cnt_checked | output | CW | Count of target checks made |
| cnt_mispred | output | CW | Count of target mismatches |

## Verification
The assertions assume that a passed slot, a killed slot and a held slot never coincide, and that the counters move only as the redirect record says. They make no assumption about sequence-number order inside a bundle. For that reason the stimulus mixes threads and draws sequence numbers at random, including values that wrap near 16'hFFFF, so the unsigned comparison is exercised on both sides. Random bundles make the predicted target equal the computed one about half of the time. Control flags are drawn independently, so conditional, indirect and non-control predicted-taken slots all occur next to real mismatches.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  // Kind of fault detected on a slot
  typedef enum logic [1:0] {
    HIT_NONE    = 2'd0,
    HIT_TARGET  = 2'd1,
    HIT_NONCTRL = 2'd2
  } hit_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/dtb_slot_eval.sv
module dtb_slot_eval
  import dtb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          valid,
  input  logic [AW-1:0] pc,
  input  logic          pred_taken,
  input  logic [AW-1:0] pred_tgt,
  input  logic          ctrl,
  input  logic          direct,
  input  logic          uncond,
  input  logic [AW-1:0] calc_tgt,
  output hit_e          kind,
  output logic          checked,
  output logic [AW-1:0] fix_tgt,
  output logic [AW-1:0] fall_pc
);
  logic resolvable;

  assign fall_pc    = pc + AW'(INSN_BYTES);
  assign resolvable = valid && ctrl && direct && uncond;
  assign checked    = resolvable;

  always_comb begin
    kind    = HIT_NONE;
    fix_tgt = pred_tgt;
    if (valid && pred_taken && !ctrl) begin
      kind    = HIT_NONCTRL;
      fix_tgt = fall_pc;
    end else if (resolvable && (calc_tgt != pred_tgt)) begin
      kind    = HIT_TARGET;
      fix_tgt = calc_tgt;
    end
  end
endmodule

// File: rtl/dtb_first_hit.sv
module dtb_first_hit #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  hit,
  output logic [W-1:0]  first_oh,
  output logic [W-1:0]  after,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    logic seen;
    seen     = 1'b0;
    first_oh = '0;
    after    = '0;
    idx      = '0;
    for (int i = 0; i < W; i++) begin
      after[i]    = seen;
      first_oh[i] = hit[i] && !seen;
      if (hit[i] && !seen) idx = IW'(i);
      seen = seen | hit[i];
    end
    any = seen;
  end
endmodule

// File: rtl/dtb_counters.sv
module dtb_counters #(
  parameter int W  = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  chk_mask,
  input  logic          mis_inc,
  output logic [CW-1:0] cnt_checked,
  output logic [CW-1:0] cnt_mispred
);
  logic [CW-1:0] chk_add;

  always_comb begin
    chk_add = '0;
    for (int i = 0; i < W; i++) chk_add = chk_add + CW'(chk_mask[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_checked <= '0;
      cnt_mispred <= '0;
    end else begin
      cnt_checked <= cnt_checked + chk_add;
      if (mis_inc) cnt_mispred <= cnt_mispred + 1'b1;
    end
  end

  p_mis_step_r11: assert property (@(posedge clk) disable iff (rst)
    mis_inc |=> cnt_mispred == $past(cnt_mispred) + 1'b1);
  p_mis_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !mis_inc |=> $stable(cnt_mispred));
endmodule

// File: rtl/dtb_checker.sv
module dtb_checker
  import dtb_pkg::*;
#(
  parameter int W  = 4,
  parameter int TW = 2,
  parameter int SW = 16,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    in_valid,
  input  logic [W*TW-1:0] in_tid,
  input  logic [W*SW-1:0] in_seq,
  input  logic [W*AW-1:0] in_pc,
  input  logic [W-1:0]    in_pred_taken,
  input  logic [W*AW-1:0] in_pred_tgt,
  input  logic [W-1:0]    in_ctrl,
  input  logic [W-1:0]    in_direct,
  input  logic [W-1:0]    in_uncond,
  input  logic [W*AW-1:0] in_calc_tgt,
  input  logic [W-1:0]    in_no_src,
  output logic [W-1:0]    out_valid,
  output logic [W-1:0]    out_kill,
  output logic [W-1:0]    out_hold,
  output logic [W-1:0]    out_ready,
  output logic [W*AW-1:0] out_pred_tgt,
  output logic            rd_valid,
  output logic [TW-1:0]   rd_tid,
  output logic [SW-1:0]   rd_seq,
  output logic [AW-1:0]   rd_next_pc,
  output logic            rd_taken,
  output logic            rd_nonctrl,
  output logic [CW-1:0]   cnt_checked,
  output logic [CW-1:0]   cnt_mispred
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  hit_e          kind    [W];
  logic [AW-1:0] fix_tgt [W];
  logic [AW-1:0] fall_pc [W];
  logic [W-1:0]  checked;
  logic [W-1:0]  hit;
  logic [W-1:0]  first_oh, after;
  logic          any_hit;
  logic [IW-1:0] hit_idx;

  // Per-slot evaluation
  for (genvar g = 0; g < W; g++) begin : g_slot
    dtb_slot_eval #(.AW(AW)) u_eval (
      .valid      (in_valid[g]),
      .pc         (in_pc[g*AW +: AW]),
      .pred_taken (in_pred_taken[g]),
      .pred_tgt   (in_pred_tgt[g*AW +: AW]),
      .ctrl       (in_ctrl[g]),
      .direct     (in_direct[g]),
      .uncond     (in_uncond[g]),
      .calc_tgt   (in_calc_tgt[g*AW +: AW]),
      .kind       (kind[g]),
      .checked    (checked[g]),
      .fix_tgt    (fix_tgt[g]),
      .fall_pc    (fall_pc[g])
    );
    assign hit[g] = (kind[g] != HIT_NONE);
  end

  dtb_first_hit #(.W(W)) u_first (
    .hit      (hit),
    .first_oh (first_oh),
    .after    (after),
    .any      (any_hit),
    .idx      (hit_idx)
  );

  // Fields of the oldest faulting slot
  logic [TW-1:0] t_tid;
  logic [SW-1:0] t_seq;
  logic [AW-1:0] t_next, t_fall;
  hit_e          t_kind;

  always_comb begin
    t_tid  = in_tid[hit_idx*TW +: TW];
    t_seq  = in_seq[hit_idx*SW +: SW];
    t_next = fix_tgt[hit_idx];
    t_fall = fall_pc[hit_idx];
    t_kind = kind[hit_idx];
  end

  // Slot dispositions
  logic [W-1:0]    n_pass, n_kill, n_hold, n_ready;
  logic [W*AW-1:0] n_tgt;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      n_pass[i]  = in_valid[i] && !after[i];
      n_kill[i]  = in_valid[i] && after[i] &&
                   (in_tid[i*TW +: TW] == t_tid) &&
                   (in_seq[i*SW +: SW] > t_seq);
      n_hold[i]  = in_valid[i] && after[i] && !n_kill[i];
      n_ready[i] = n_pass[i] && in_no_src[i];
      if (!n_pass[i])
        n_tgt[i*AW +: AW] = '0;
      else if (first_oh[i])
        n_tgt[i*AW +: AW] = fix_tgt[i];
      else
        n_tgt[i*AW +: AW] = in_pred_tgt[i*AW +: AW];
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= '0;
      out_kill     <= '0;
      out_hold     <= '0;
      out_ready    <= '0;
      out_pred_tgt <= '0;
      rd_valid     <= 1'b0;
      rd_tid       <= '0;
      rd_seq       <= '0;
      rd_next_pc   <= '0;
      rd_taken     <= 1'b0;
      rd_nonctrl   <= 1'b0;
    end else begin
      out_valid    <= n_pass;
      out_kill     <= n_kill;
      out_hold     <= n_hold;
      out_ready    <= n_ready;
      out_pred_tgt <= n_tgt;
      rd_valid     <= any_hit;
      rd_tid       <= any_hit ? t_tid : '0;
      rd_seq       <= any_hit ? t_seq : '0;
      rd_next_pc   <= any_hit ? t_next : '0;
      rd_taken     <= any_hit && (t_next != t_fall);
      rd_nonctrl   <= any_hit && (t_kind == HIT_NONCTRL);
    end
  end

  dtb_counters #(.W(W), .CW(CW)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .chk_mask    (checked & ~after),
    .mis_inc     (any_hit && (t_kind == HIT_TARGET)),
    .cnt_checked (cnt_checked),
    .cnt_mispred (cnt_mispred)
  );

  // Assertions
  for (genvar g = 0; g < W; g++) begin : g_chk
    p_one_state_r5: assert property (@(posedge clk) disable iff (rst)
      $countones({out_valid[g], out_kill[g], out_hold[g]}) <= 1);
    p_ready_passed_r10: assert property (@(posedge clk) disable iff (rst)
      out_ready[g] |-> out_valid[g]);
  end

  p_kill_needs_redirect_r4: assert property (@(posedge clk) disable iff (rst)
    (|out_kill) |-> rd_valid);
  p_hold_needs_redirect_r5: assert property (@(posedge clk) disable iff (rst)
    (|out_hold) |-> rd_valid);
  p_nonctrl_not_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_nonctrl) |-> !rd_taken);
  p_idle_record_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_next_pc == '0 && !rd_taken && !rd_nonctrl));
  p_mis_matches_record_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_nonctrl) |-> cnt_mispred != $past(cnt_mispred));
endmodule

// File: tb/sim_dtb_checker.sv
module sim_dtb_checker;
  localparam int W = 4, TW = 2, SW = 16, AW = 32, CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0]    in_valid, in_pred_taken, in_ctrl, in_direct, in_uncond, in_no_src;
  logic [W*TW-1:0] in_tid;
  logic [W*SW-1:0] in_seq;
  logic [W*AW-1:0] in_pc, in_pred_tgt, in_calc_tgt;
  logic [W-1:0]    out_valid, out_kill, out_hold, out_ready;
  logic [W*AW-1:0] out_pred_tgt;
  logic            rd_valid, rd_taken, rd_nonctrl;
  logic [TW-1:0]   rd_tid;
  logic [SW-1:0]   rd_seq;
  logic [AW-1:0]   rd_next_pc;
  logic [CW-1:0]   cnt_checked, cnt_mispred;

  dtb_checker #(.W(W), .TW(TW), .SW(SW), .AW(AW), .CW(CW)) u0 (.*);

  integer checks = 0, fails = 0;

  // expected values
  logic [W-1:0]    e_valid, e_kill, e_hold, e_ready;
  logic [W*AW-1:0] e_tgt;
  logic            e_rd, e_taken, e_nonctrl;
  logic [TW-1:0]   e_tid;
  logic [SW-1:0]   e_seq;
  logic [AW-1:0]   e_next;
  logic [CW-1:0]   e_chk, e_mis;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = '0; in_pred_taken = '0; in_ctrl = '0; in_direct = '0;
    in_uncond = '0; in_no_src = '0; in_tid = '0; in_seq = '0;
    in_pc = '0; in_pred_tgt = '0; in_calc_tgt = '0;
  endtask

  task automatic put(input int s, input logic [1:0] tid, input logic [15:0] seq,
                     input logic [31:0] pc, input bit pt, input logic [31:0] ptgt,
                     input bit c, input bit d, input bit u, input logic [31:0] ctgt,
                     input bit ns);
    in_valid[s] = 1'b1; in_tid[s*TW +: TW] = tid; in_seq[s*SW +: SW] = seq;
    in_pc[s*AW +: AW] = pc; in_pred_taken[s] = pt; in_pred_tgt[s*AW +: AW] = ptgt;
    in_ctrl[s] = c; in_direct[s] = d; in_uncond[s] = u;
    in_calc_tgt[s*AW +: AW] = ctgt; in_no_src[s] = ns;
  endtask

  // Behavioural model: walk the bundle oldest first, stop at the first fault
  task automatic model();
    int stop;
    logic [1:0] ft; logic [15:0] fs; logic [31:0] fnext, fpc;
    bit fnc;
    stop = -1; ft = '0; fs = '0; fnext = '0; fpc = '0; fnc = 0;
    e_valid = '0; e_kill = '0; e_hold = '0; e_ready = '0; e_tgt = '0;
    for (int i = 0; i < W; i++) begin
      if (!in_valid[i]) continue;
      if (stop >= 0) begin
        if (in_tid[i*TW +: TW] == ft && in_seq[i*SW +: SW] > fs) e_kill[i] = 1'b1;
        else e_hold[i] = 1'b1;
        continue;
      end
      e_valid[i] = 1'b1;
      e_ready[i] = in_no_src[i];
      e_tgt[i*AW +: AW] = in_pred_tgt[i*AW +: AW];
      if (in_ctrl[i] && in_direct[i] && in_uncond[i]) e_chk = e_chk + 1'b1;
      if (in_pred_taken[i] && !in_ctrl[i]) begin
        stop = i; fnc = 1; fnext = in_pc[i*AW +: AW] + 4;
      end else if (in_ctrl[i] && in_direct[i] && in_uncond[i] &&
                   in_calc_tgt[i*AW +: AW] != in_pred_tgt[i*AW +: AW]) begin
        stop = i; fnc = 0; fnext = in_calc_tgt[i*AW +: AW];
        e_mis = e_mis + 1'b1;
      end
      if (stop == i) begin
        ft = in_tid[i*TW +: TW]; fs = in_seq[i*SW +: SW]; fpc = in_pc[i*AW +: AW];
        e_tgt[i*AW +: AW] = fnext;
      end
    end
    e_rd = (stop >= 0);
    e_tid = e_rd ? ft : '0; e_seq = e_rd ? fs : '0; e_next = e_rd ? fnext : '0;
    e_nonctrl = e_rd && fnc;
    e_taken = e_rd && (fnext != fpc + 32'd4);
  endtask

  task automatic compare();
    chk(out_valid == e_valid, "R5 pass", out_valid, e_valid);
    chk(out_hold == e_hold, "R5 hold", out_hold, e_hold);
    chk(out_kill == e_kill, "R4 kill", out_kill, e_kill);
    chk(out_pred_tgt == e_tgt, "R6 target", out_pred_tgt, e_tgt);
    chk(out_ready == e_ready, "R10 ready", out_ready, e_ready);
    chk(rd_valid == e_rd && rd_tid == e_tid && rd_seq == e_seq, "R2 record", {rd_valid, rd_tid, rd_seq}, {e_rd, e_tid, e_seq});
    chk(rd_next_pc == e_next, "R2 next pc", rd_next_pc, e_next);
    chk(rd_taken == e_taken, "R3 taken", rd_taken, e_taken);
    chk(rd_nonctrl == e_nonctrl, "R7 nonctrl", rd_nonctrl, e_nonctrl);
    chk(cnt_checked == e_chk && cnt_mispred == e_mis, "R11 counters", {cnt_checked, cnt_mispred}, {e_chk, e_mis});
  endtask

  // Apply the current inputs for one cycle and compare on the next sample
  task automatic step();
    model();
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    clear_in();
    in_valid = 4'hF; in_pred_taken = 4'hF;  // ignored under reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_in();
    // R1: reset state
    e_valid = '0; e_kill = '0; e_hold = '0; e_ready = '0; e_tgt = '0;
    e_rd = 0; e_tid = '0; e_seq = '0; e_next = '0; e_taken = 0; e_nonctrl = 0;
    e_chk = '0; e_mis = '0;
    compare();
    chk(out_valid == '0 && rd_valid == 0, "R1 reset", {out_valid, rd_valid}, 0);

    // R2 R3 R4 R5 R6: mismatch in slot 1, same-thread younger in 2, other thread in 3
    clear_in();
    put(0, 2'd1, 16'd10, 32'h100, 0, 32'h0, 0, 0, 0, 32'h0, 1);
    put(1, 2'd1, 16'd11, 32'h104, 1, 32'h200, 1, 1, 1, 32'h300, 0);
    put(2, 2'd1, 16'd12, 32'h300, 0, 32'h0, 0, 0, 0, 32'h0, 1);
    put(3, 2'd2, 16'd5,  32'h900, 0, 32'h0, 0, 0, 0, 32'h0, 0);
    step();
    chk(out_kill == 4'b0100 && out_hold == 4'b1000, "R4 directed kill", {out_kill, out_hold}, {4'b0100, 4'b1000});

    // R3: taken bit clear when computed target is the fall-through
    clear_in();
    put(0, 2'd0, 16'd20, 32'h400, 1, 32'h500, 1, 1, 1, 32'h404, 0);
    step();
    chk(rd_valid && !rd_taken && rd_next_pc == 32'h404, "R3 fall-through", rd_taken, 0);

    // R7: non-control predicted taken
    clear_in();
    put(0, 2'd3, 16'd30, 32'h800, 0, 32'h0, 1, 0, 1, 32'h0, 0);
    put(1, 2'd3, 16'd31, 32'h804, 1, 32'hABC, 0, 0, 0, 32'h0, 1);
    put(2, 2'd3, 16'd32, 32'h808, 0, 32'h0, 0, 0, 0, 32'h0, 0);
    step();
    chk(rd_nonctrl && rd_next_pc == 32'h808 && out_kill == 4'b0100, "R7 directed", {rd_nonctrl, rd_next_pc}, {1'b1, 32'h808});

    // R8: two faults, first defines the record
    clear_in();
    put(0, 2'd0, 16'd40, 32'h10, 1, 32'h20, 1, 1, 1, 32'h30, 0);
    put(1, 2'd0, 16'd41, 32'h30, 1, 32'h40, 1, 1, 1, 32'h50, 0);
    step();
    chk(rd_seq == 16'd40 && rd_next_pc == 32'h30, "R8 first fault", rd_seq, 16'd40);

    // R9: conditional and indirect with differing targets
    clear_in();
    put(0, 2'd0, 16'd50, 32'h10, 1, 32'h20, 1, 1, 0, 32'h90, 0);
    put(1, 2'd0, 16'd51, 32'h20, 1, 32'h60, 1, 0, 1, 32'h70, 0);
    step();
    chk(!rd_valid && out_valid == 4'b0011, "R9 no redirect", rd_valid, 0);

    // R4: sequence wrap, younger by number but smaller seq is held
    clear_in();
    put(0, 2'd1, 16'hFFFE, 32'h10, 1, 32'h20, 1, 1, 1, 32'h24, 0);
    put(1, 2'd1, 16'hFFFF, 32'h24, 0, 32'h0, 0, 0, 0, 32'h0, 0);
    put(2, 2'd1, 16'h0001, 32'h28, 0, 32'h0, 0, 0, 0, 32'h0, 0);
    step();
    chk(out_kill == 4'b0010 && out_hold == 4'b0100, "R4 unsigned compare", {out_kill, out_hold}, {4'b0010, 4'b0100});

    // R12: invalid slots with fault-like contents
    clear_in();
    in_pred_taken = 4'hF; in_no_src = 4'hF; in_calc_tgt = '1;
    put(2, 2'd0, 16'd60, 32'h50, 0, 32'h0, 0, 0, 0, 32'h0, 1);
    step();
    chk(out_valid == 4'b0100 && !rd_valid && out_ready == 4'b0100, "R12 invalid ignored", out_valid, 4'b0100);

    // Random bundles, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      clear_in();
      for (int s = 0; s < W; s++) begin
        logic [31:0] pt;
        pt = $urandom & 32'hFFFC;
        put(s, 2'($urandom_range(0, 3)), 16'($urandom), $urandom & 32'hFFFC,
            ($urandom_range(0, 3) == 0), pt,
            ($urandom_range(0, 3) != 0), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1) ? pt : ($urandom & 32'hFFFC), $urandom_range(0, 1));
        in_valid[s] = ($urandom_range(0, 4) != 0);
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule